// File: doc/BRIEF.md
# Cascadable Binary Content-Addressable Memory

This block stores a small table of 32-bit keys, 32 entries by default, and answers the question "which entry holds this key?" in a fixed number of cycles. A write port loads a key into a chosen entry, or clears that entry's valid flag. A search port accepts one key per cycle and compares it against every valid entry at the same time. It returns a hit flag and the encoded address of the matching entry. It does not return stored data for a given address.

The search key is captured in an input register. The parallel compare and the lowest-address priority pick run in the following cycle and end in an output register, so every result appears two clock edges after its request. Several instances can be chained into one deeper table. Each instance receives the hit flag and address produced by the instance ahead of it, and an upstream hit always wins. Without an upstream hit, the instance reports its own match offset by a base address set per instance. Back-to-back searches let a stream of symbols be replaced, one per cycle, by the index of the entry that holds each one. This suits dictionary compression and address translation.

Top module: `cam_block`

## Requirements
- R1: After reset every entry is invalid and `res_vld` is 0. A search issued right after reset, even for key 0, reports no hit.
- R2: `res_vld` is 1 on the second rising edge after a cycle with `srch_en` = 1, and is 0 otherwise.
- R3: A search for a key held in a valid entry reports `res_hit` = 1 and `res_addr` = `BASE_ADDR` + entry index.
- R4: When neither the upstream instance nor any local entry matches, `res_hit` is 0 and `res_addr` is 0.
- R5: A write with `wr_set` = 0 invalidates the entry, and an invalid entry never matches, even if it still holds the key.
- R6: When several valid entries hold the searched key, the lowest entry index is reported.
- R7: A write presented in the same cycle as a search is not seen by that search. It is seen by a search presented one cycle later.
- R8: While `casc_in_hit` = 1 and `res_vld` = 1, the output carries `res_hit` = 1 and `res_addr` = `casc_in_addr`, whatever the local result. The cascade inputs belong to the cycle in which the result is presented.
- R9: With `casc_in_hit` = 0, a local hit address lies in the range from `BASE_ADDR` to `BASE_ADDR` + entries − 1.
- R10: Searches issued on consecutive cycles each produce one result, in issue order, on consecutive cycles.
- R11: A write with `wr_set` = 1 to an entry that is already valid replaces its key, and the old key no longer matches there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_set | input | 1 | 1 loads key and marks entry valid, 0 invalidates entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_key | input | KEY_W | Key to store |
| srch_en | input | 1 | Search request |
| srch_key | input | KEY_W | Key to look up |
| casc_in_hit | input | 1 | Hit flag from the upstream (higher priority) instance |
| casc_in_addr | input | CASC_AW | Address from the upstream instance |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | Match found (upstream or local) |
| res_addr | output | CASC_AW | Global address of the match, 0 on miss |

## Verification
The hardest condition to reach from the ports is a write and a search meeting in the same cycle. The bench places both on the same clock edge: it loads a new key into an occupied entry while searching for that same key. It then repeats the search on the next cycle, so the miss-then-hit pair shows where the write becomes visible. Multiple matches are built by storing one key in two entries and then invalidating the lower one, which shows the priority pick moving to the higher index. Cascade priority is exercised by asserting the upstream hit both when the local table also matches and when it does not.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int CAM_ENTRIES_DEF = 32;
    localparam int CAM_KEY_W_DEF   = 32;
    localparam int CAM_CASC_AW_DEF = 8;

    // index width, never below one bit
    function automatic int idx_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

    typedef enum logic {
        WR_CLEAR = 1'b0,
        WR_LOAD  = 1'b1
    } wr_op_e;
endpackage

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES_DEF,
    parameter int KEY_W   = CAM_KEY_W_DEF,
    localparam int IDX_W  = idx_width(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  wr_op_e                          wr_op,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [KEY_W-1:0]                wr_key,
    output logic [ENTRIES-1:0]              ent_vld,
    output logic [ENTRIES-1:0][KEY_W-1:0]   ent_key
);
    typedef struct packed {
        logic               en;
        wr_op_e             op;
        logic [IDX_W-1:0]   idx;
        logic [KEY_W-1:0]   key;
    } wr_req_t;

    wr_req_t wq;

    // staging register: a write lands one edge after capture
    always_ff @(posedge clk) begin
        if (rst) begin
            wq <= '0;
        end else begin
            wq.en  <= wr_en;
            wq.op  <= wr_op;
            wq.idx <= wr_idx;
            wq.key <= wr_key;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[g] <= 1'b0;
            end else if (wq.en && (wq.idx == IDX_W'(g))) begin
                ent_vld[g] <= (wq.op == WR_LOAD);
            end
        end

        always_ff @(posedge clk) begin
            if (wq.en && (wq.idx == IDX_W'(g)) && (wq.op == WR_LOAD)) begin
                ent_key[g] <= wq.key;
            end
        end
    end
endmodule

// File: rtl/cam_match.sv
module cam_match
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES_DEF,
    parameter int KEY_W   = CAM_KEY_W_DEF
) (
    input  logic [KEY_W-1:0]                key,
    input  logic [ENTRIES-1:0]              ent_vld,
    input  logic [ENTRIES-1:0][KEY_W-1:0]   ent_key,
    output logic [ENTRIES-1:0]              hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_key[g] == key);
    end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES_DEF,
    localparam int IDX_W  = idx_width(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_block.sv
module cam_block
    import cam_pkg::*;
#(
    parameter int ENTRIES   = CAM_ENTRIES_DEF,
    parameter int KEY_W     = CAM_KEY_W_DEF,
    parameter int CASC_AW   = CAM_CASC_AW_DEF,
    parameter int BASE_ADDR = 0,
    localparam int IDX_W    = idx_width(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_set,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [KEY_W-1:0]    wr_key,
    input  logic                srch_en,
    input  logic [KEY_W-1:0]    srch_key,
    input  logic                casc_in_hit,
    input  logic [CASC_AW-1:0]  casc_in_addr,
    output logic                res_vld,
    output logic                res_hit,
    output logic [CASC_AW-1:0]  res_addr
);
    logic [ENTRIES-1:0]             ent_vld;
    logic [ENTRIES-1:0][KEY_W-1:0]  ent_key;
    logic [ENTRIES-1:0]             hit_vec;
    logic                           loc_any;
    logic [IDX_W-1:0]               loc_idx;

    logic               s1_vld;
    logic [KEY_W-1:0]   s1_key;
    logic               s2_vld;
    logic               s2_hit;
    logic [IDX_W-1:0]   s2_idx;

    cam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_op   (wr_op_e'(wr_set)),
        .wr_idx  (wr_idx),
        .wr_key  (wr_key),
        .ent_vld (ent_vld),
        .ent_key (ent_key)
    );

    // input register
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_key <= '0;
        end else begin
            s1_vld <= srch_en;
            s1_key <= srch_key;
        end
    end

    cam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) match_i (
        .key     (s1_key),
        .ent_vld (ent_vld),
        .ent_key (ent_key),
        .hit_vec (hit_vec)
    );

    cam_prio_enc #(.ENTRIES(ENTRIES)) enc_i (
        .vec (hit_vec),
        .any (loc_any),
        .idx (loc_idx)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_hit <= 1'b0;
            s2_idx <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_hit <= s1_vld && loc_any;
            s2_idx <= loc_any ? loc_idx : '0;
        end
    end

    // cascade merge: upstream wins, else local offset by base
    always_comb begin
        res_vld  = s2_vld;
        res_hit  = 1'b0;
        res_addr = '0;
        if (s2_vld) begin
            if (casc_in_hit) begin
                res_hit  = 1'b1;
                res_addr = casc_in_addr;
            end else if (s2_hit) begin
                res_hit  = 1'b1;
                res_addr = CASC_AW'(BASE_ADDR) + CASC_AW'(s2_idx);
            end
        end
    end
endmodule

// File: rtl/cam_block_chk.sv
module cam_block_chk #(
    parameter int ENTRIES   = 32,
    parameter int CASC_AW   = 8,
    parameter int BASE_ADDR = 0
) (
    input logic                clk,
    input logic                rst,
    input logic                srch_en,
    input logic                casc_in_hit,
    input logic [CASC_AW-1:0]  casc_in_addr,
    input logic                res_vld,
    input logic                res_hit,
    input logic [CASC_AW-1:0]  res_addr
);
    localparam logic [CASC_AW:0] LO_ADDR = (CASC_AW+1)'(BASE_ADDR);
    localparam logic [CASC_AW:0] HI_ADDR = (CASC_AW+1)'(BASE_ADDR + ENTRIES);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_vld);

    // R2
    lat_hit_chk: assert property (@(posedge clk) disable iff (rst)
        srch_en |-> ##2 res_vld);

    // R2
    lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !srch_en |-> ##2 !res_vld);

    // R4
    miss_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_hit) |-> (res_addr == '0));

    // R8
    casc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && casc_in_hit) |-> (res_hit && res_addr == casc_in_addr));

    // R9
    local_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && res_hit && !casc_in_hit) |->
            ({1'b0, res_addr} >= LO_ADDR && {1'b0, res_addr} < HI_ADDR));
endmodule

bind cam_block cam_block_chk #(
    .ENTRIES   (ENTRIES),
    .CASC_AW   (CASC_AW),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .srch_en      (srch_en),
    .casc_in_hit  (casc_in_hit),
    .casc_in_addr (casc_in_addr),
    .res_vld      (res_vld),
    .res_hit      (res_hit),
    .res_addr     (res_addr)
);

// File: tb/cam_block_tb_top.sv
module cam_block_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENT  = 32;
    localparam int KW   = 32;
    localparam int AW   = 8;
    localparam int BASE = 64;
    localparam int IW   = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           wr_set = 1'b0;
    logic [IW-1:0]  wr_idx = '0;
    logic [KW-1:0]  wr_key = '0;
    logic           srch_en = 1'b0;
    logic [KW-1:0]  srch_key = '0;
    logic           casc_in_hit = 1'b0;
    logic [AW-1:0]  casc_in_addr = '0;
    logic           res_vld;
    logic           res_hit;
    logic [AW-1:0]  res_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_block #(.ENTRIES(ENT), .KEY_W(KW), .CASC_AW(AW), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx), .wr_key(wr_key),
        .srch_en(srch_en), .srch_key(srch_key),
        .casc_in_hit(casc_in_hit), .casc_in_addr(casc_in_addr),
        .res_vld(res_vld), .res_hit(res_hit), .res_addr(res_addr)
    );

    task automatic check_res(input string tag, input logic ev, input logic eh,
                             input logic [AW-1:0] ea);
        checks++;
        if (res_vld !== ev || res_hit !== eh || res_addr !== ea) begin
            errors++;
            $display("FAIL %s: got vld=%0b hit=%0b addr=%0d, expected vld=%0b hit=%0b addr=%0d",
                     tag, res_vld, res_hit, res_addr, ev, eh, ea);
        end
    endtask

    task automatic do_write(input logic set, input int idx, input logic [KW-1:0] key);
        @(negedge clk);
        wr_en = 1'b1; wr_set = set; wr_idx = IW'(idx); wr_key = key;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // single search: result checked two edges after the request edge
    task automatic do_search(input string tag, input logic [KW-1:0] key,
                             input logic ch, input logic [AW-1:0] ca,
                             input logic eh, input logic [AW-1:0] ea);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        @(negedge clk);
        srch_en = 1'b0;
        check_res({tag, " (latency gap, R2)"}, 1'b0, 1'b0, '0);
        @(negedge clk);
        casc_in_hit = ch; casc_in_addr = ca;
        #1;
        check_res(tag, 1'b1, eh, ea);
        casc_in_hit = 1'b0; casc_in_addr = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_res("R1 reset idle", 1'b0, 1'b0, '0);
        do_search("R1 search after reset key 0", 32'h0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_basic;
        do_write(1'b1, 0, 32'h0000_6541);
        do_write(1'b1, 1, 32'h0000_2712);
        do_write(1'b1, 31, 32'hDEAD_BEEF);
        do_search("R3 hit entry 0", 32'h0000_6541, 1'b0, '0, 1'b1, AW'(BASE + 0));
        do_search("R3 hit entry 1", 32'h0000_2712, 1'b0, '0, 1'b1, AW'(BASE + 1));
        do_search("R9 hit top entry 31", 32'hDEAD_BEEF, 1'b0, '0, 1'b1, AW'(BASE + 31));
        do_search("R4 miss", 32'h1234_5678, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_invalid_prio;
        do_write(1'b1, 9, 32'hCAFE_0001);
        do_write(1'b1, 20, 32'hCAFE_0001);
        do_search("R6 lowest of two matches", 32'hCAFE_0001, 1'b0, '0, 1'b1, AW'(BASE + 9));
        do_write(1'b0, 9, 32'h0);
        do_search("R5 invalidated entry skipped", 32'hCAFE_0001, 1'b0, '0, 1'b1, AW'(BASE + 20));
        do_write(1'b0, 20, 32'hCAFE_0001);
        do_search("R5 all copies invalid", 32'hCAFE_0001, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_overwrite;
        do_write(1'b1, 4, 32'h0000_AAAA);
        do_write(1'b1, 4, 32'h0000_BBBB);
        do_search("R11 old key gone", 32'h0000_AAAA, 1'b0, '0, 1'b0, '0);
        do_search("R11 new key found", 32'h0000_BBBB, 1'b0, '0, 1'b1, AW'(BASE + 4));
    endtask

    task automatic t_collision;
        do_write(1'b1, 5, 32'h5555_0000);
        @(negedge clk);
        wr_en = 1'b1; wr_set = 1'b1; wr_idx = IW'(5); wr_key = 32'h5555_1111;
        srch_en = 1'b1; srch_key = 32'h5555_1111;
        @(negedge clk);
        wr_en = 1'b0;
        srch_key = 32'h5555_1111;
        @(negedge clk);
        srch_en = 1'b0;
        check_res("R7 same-cycle search misses", 1'b1, 1'b0, '0);
        @(negedge clk);
        check_res("R7 next-cycle search hits", 1'b1, 1'b1, AW'(BASE + 5));
    endtask

    task automatic t_cascade;
        do_write(1'b1, 2, 32'h0C0C_0C0C);
        do_search("R8 upstream beats local hit", 32'h0C0C_0C0C, 1'b1, 8'd7, 1'b1, 8'd7);
        do_search("R8 upstream hit, local miss", 32'h7777_7777, 1'b1, 8'd3, 1'b1, 8'd3);
        do_search("R9 local hit offset by base", 32'h0C0C_0C0C, 1'b0, 8'd3, 1'b1, AW'(BASE + 2));
    endtask

    // compression stream: one symbol per cycle
    task automatic t_stream;
        logic [KW-1:0] syms [4] = '{32'h42, 32'h59, 32'h83, 32'h27};
        int            exp  [6] = '{1, 2, 2, 3, 1, 0};
        logic [KW-1:0] seq  [6];
        for (int i = 0; i < 4; i++) do_write(1'b1, 10 + i, syms[i]);
        seq[0] = 32'h59; seq[1] = 32'h83; seq[2] = 32'h83;
        seq[3] = 32'h27; seq[4] = 32'h59; seq[5] = 32'h42;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            srch_en  = (i < 6);
            srch_key = (i < 6) ? seq[i] : '0;
            if (i >= 2) begin
                #1;
                check_res($sformatf("R10 stream symbol %0d", i - 2), 1'b1, 1'b1,
                          AW'(BASE + 10 + exp[i - 2]));
            end
        end
        @(negedge clk);
        srch_en = 1'b0;
        @(negedge clk);
        check_res("R10 stream drained", 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_invalid_prio();
        t_overwrite();
        t_collision();
        t_cascade();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule